// File: doc/BRIEF.md
# Three-Phase Starvation Detector with Shared Event Interrupt

This block watches the energy accumulators of three phases and decides, for each phase separately, whether that phase has stopped carrying load. Every phase owns a timer that counts sample ticks. An energy-increment strobe on a phase reloads that phase's timer. If a programmed number of ticks pass with no increment, the phase is declared idle. While a phase is idle, its accumulation-enable output is held low, so the downstream accumulator and pulse generator ignore that phase.

A single sticky event flag records every transition of any phase into or out of the idle state. The flag changes on the same clock edge as the per-phase state vector. Software can therefore read the vector to see which phases are idle now. When the event flag is set and the interrupt enable is on, an active-low interrupt line is pulled low. Writing a one to the flag clears it. A timeout of zero turns detection off and forces every phase out of the idle state.

Top module: `nold_detector`

## Requirements
- R1: After reset, `idle_o` is 3'b000, `accum_en_o` is 3'b111, `evt_o` is 0 and `irq_n_o` is 1.
- R2: A phase with a nonzero timeout N becomes idle at the clock edge that samples the N-th asserted `tick_i` since its last increment. Cycles without `tick_i` do not advance the count. In `idle_o`, bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. A bit value of 1 means idle.
- R3: `accum_en_o[k]` is 0 exactly while `idle_o[k]` is 1.
- R4: While `timeout_i` is 0, no phase becomes idle. A phase that is already idle leaves the idle state at the next edge.
- R5: An `incr_i[k]` pulse clears phase k's timer. If phase k is idle, it leaves the idle state at that same edge, so the change is visible in the following cycle.
- R6: `evt_o` becomes 1 at the same edge at which any bit of `idle_o` changes, whether the change is into or out of the idle state.
- R7: `irq_n_o` is 0 exactly when `evt_o` is 1 and `irq_en_i` is 1. The line responds to `irq_en_i` within the same cycle.
- R8: A cycle with `evt_wr_i`=1 and `evt_wdata_i`=1 clears `evt_o` at the next edge. A write with `evt_wdata_i`=0 leaves `evt_o` unchanged. Without a clearing write, `evt_o` stays set.
- R9: If a phase transition happens in the same cycle as a clearing write, `evt_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick that advances the timers |
| incr_i | input | 3 | Per-phase energy-increment strobe (bit 0 = A) |
| timeout_i | input | 16 | Idle timeout in ticks; 0 disables detection |
| irq_en_i | input | 1 | Interrupt enable for the event flag |
| evt_wr_i | input | 1 | Write strobe for the event flag |
| evt_wdata_i | input | 1 | Write data; 1 clears the flag |
| idle_o | output | 3 | Per-phase idle state (1 = idle) |
| evt_o | output | 1 | Sticky transition event flag |
| irq_n_o | output | 1 | Interrupt, active low |
| accum_en_o | output | 3 | Per-phase accumulation enable |

## Verification
The phase state, the accumulation enables and the event flag all come from registers. Each of these results is due at the first rising edge that samples the stimulus causing it, so it can be seen one cycle after that stimulus. The interrupt line is combinational from the event register and `irq_en_i`. It follows a change of enable in the same cycle and a change of the event flag in the cycle the flag changes. The bench changes inputs at the falling edge and samples outputs at the next falling edge, which is exactly one rising edge later. For the enable change, it samples one time unit after the change. Timeout counts are checked one tick before and at the expected entry edge, with tick-free cycles placed in between.

// File: rtl/nold_pkg.sv
package nold_pkg;

  localparam int unsigned NOLD_PHASES = 3;
  localparam int unsigned NOLD_TW     = 16;

  typedef logic [NOLD_TW-1:0]     tmo_t;
  typedef logic [NOLD_PHASES-1:0] phvec_t;

  // True when one more tick reaches or passes the programmed limit.
  function automatic logic f_tick_expires(input tmo_t cnt, input tmo_t lim);
    logic [NOLD_TW:0] nxt;
    nxt = {1'b0, cnt} + {{NOLD_TW{1'b0}}, 1'b1};
    return (nxt >= {1'b0, lim});
  endfunction

  // Next value of the sticky event flag: a new event beats a clear.
  function automatic logic f_evt_next(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

endpackage

// File: rtl/nold_phase_timer.sv
module nold_phase_timer
  import nold_pkg::*;
#(
  parameter int unsigned TW = NOLD_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          incr_i,
  input  logic [TW-1:0] limit_i,
  output logic          idle_q_o,
  output logic          idle_d_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          idle_q, idle_d;
  logic          disabled;
  logic          expires;

  assign disabled = (limit_i == '0);
  assign expires  = f_tick_expires(tmo_t'(cnt_q), tmo_t'(limit_i));

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = idle_q;
    if (disabled) begin
      cnt_d  = '0;
      idle_d = 1'b0;
    end else if (incr_i) begin
      cnt_d  = '0;
      idle_d = 1'b0;
    end else if (tick_i && !idle_q) begin
      if (expires) idle_d = 1'b1;
      else         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign idle_q_o = idle_q;
  assign idle_d_o = idle_d;

endmodule

// File: rtl/nold_event_merge.sv
module nold_event_merge #(
  parameter int unsigned NPH = 3
) (
  input  logic [NPH-1:0] idle_q_i,
  input  logic [NPH-1:0] idle_d_i,
  output logic [NPH-1:0] enter_o,
  output logic [NPH-1:0] leave_o,
  output logic           any_evt_o
);

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    assign enter_o[k] = idle_d_i[k] & ~idle_q_i[k];
    assign leave_o[k] = ~idle_d_i[k] & idle_q_i[k];
  end

  assign any_evt_o = |(enter_o | leave_o);

endmodule

// File: rtl/nold_evt_irq.sv
module nold_evt_irq
  import nold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic irq_en_i,
  output logic evt_o,
  output logic irq_n_o
);

  logic evt_q;
  logic clr;

  assign clr = wr_i & wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= f_evt_next(evt_q, clr, any_evt_i);
  end

  assign evt_o   = evt_q;
  assign irq_n_o = ~(evt_q & irq_en_i);

endmodule

// File: rtl/nold_detector.sv
module nold_detector
  import nold_pkg::*;
#(
  parameter int unsigned NPH = NOLD_PHASES,
  parameter int unsigned TW  = NOLD_TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [NPH-1:0] incr_i,
  input  logic [TW-1:0]  timeout_i,
  input  logic           irq_en_i,
  input  logic           evt_wr_i,
  input  logic           evt_wdata_i,
  output logic [NPH-1:0] idle_o,
  output logic           evt_o,
  output logic           irq_n_o,
  output logic [NPH-1:0] accum_en_o
);

  logic [NPH-1:0] idle_q, idle_d;
  logic [NPH-1:0] enter_w, leave_w;
  logic           any_evt_w;

  for (genvar k = 0; k < NPH; k++) begin : g_tmr
    nold_phase_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .incr_i   (incr_i[k]),
      .limit_i  (timeout_i),
      .idle_q_o (idle_q[k]),
      .idle_d_o (idle_d[k])
    );
  end

  nold_event_merge #(.NPH(NPH)) u_merge (
    .idle_q_i  (idle_q),
    .idle_d_i  (idle_d),
    .enter_o   (enter_w),
    .leave_o   (leave_w),
    .any_evt_o (any_evt_w)
  );

  nold_evt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_evt_i (any_evt_w),
    .wr_i      (evt_wr_i),
    .wdata_i   (evt_wdata_i),
    .irq_en_i  (irq_en_i),
    .evt_o     (evt_o),
    .irq_n_o   (irq_n_o)
  );

  assign idle_o     = idle_q;
  assign accum_en_o = ~idle_q;

endmodule

// File: rtl/nold_detector_chk.sv
module nold_detector_chk #(
  parameter int unsigned NPH = 3,
  parameter int unsigned TW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_i,
  input logic [NPH-1:0] incr_i,
  input logic [TW-1:0]  timeout_i,
  input logic           irq_en_i,
  input logic           evt_wr_i,
  input logic           evt_wdata_i,
  input logic [NPH-1:0] idle_o,
  input logic           evt_o,
  input logic           irq_n_o,
  input logic [NPH-1:0] accum_en_o,
  input logic [NPH-1:0] enter_w,
  input logic [NPH-1:0] leave_w
);

  AST_ENTRY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((idle_o & ~$past(idle_o)) != '0) |-> $past(tick_i)); // R2

  AST_GATE_FOLLOWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(enter_w | leave_w)) |=> ((accum_en_o ^ idle_o) == '1)); // R3

  AST_ZERO_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == '0) |=> (idle_o == '0)); // R4

  AST_INCR_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_i != '0) |=> ((idle_o & $past(incr_i)) == '0)); // R5

  AST_CHANGE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o != $past(idle_o)) |-> evt_o); // R6

  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_o || !irq_en_i) |-> irq_n_o); // R7

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !(evt_wr_i && evt_wdata_i)) |=> evt_o); // R8

  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr_i && evt_wdata_i && (|(enter_w | leave_w))) |=> evt_o); // R9

endmodule

bind nold_detector nold_detector_chk #(.NPH(NPH), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .incr_i      (incr_i),
  .timeout_i   (timeout_i),
  .irq_en_i    (irq_en_i),
  .evt_wr_i    (evt_wr_i),
  .evt_wdata_i (evt_wdata_i),
  .idle_o      (idle_o),
  .evt_o       (evt_o),
  .irq_n_o     (irq_n_o),
  .accum_en_o  (accum_en_o),
  .enter_w     (enter_w),
  .leave_w     (leave_w)
);

// File: tb/nold_detector_tb.sv
`timescale 1ns/1ps
module nold_detector_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic [2:0]  incr_i;
  logic [15:0] timeout_i;
  logic        irq_en_i;
  logic        evt_wr_i;
  logic        evt_wdata_i;
  logic [2:0]  idle_o;
  logic        evt_o;
  logic        irq_n_o;
  logic [2:0]  accum_en_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nold_detector u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .incr_i(incr_i),
    .timeout_i(timeout_i), .irq_en_i(irq_en_i), .evt_wr_i(evt_wr_i),
    .evt_wdata_i(evt_wdata_i), .idle_o(idle_o), .evt_o(evt_o),
    .irq_n_o(irq_n_o), .accum_en_o(accum_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; outputs are sampled at the next one.
  task automatic cyc(input logic t, input logic [2:0] inc, input logic wr = 1'b0, input logic wd = 1'b0);
    tick_i = t; incr_i = inc; evt_wr_i = wr; evt_wdata_i = wd;
    @(negedge clk);
    tick_i = 1'b0; incr_i = 3'b000; evt_wr_i = 1'b0; evt_wdata_i = 1'b0;
  endtask

  task automatic do_reset(input logic [15:0] tmo, input logic en);
    rst_n = 1'b0; tick_i = 1'b0; incr_i = 3'b000; evt_wr_i = 1'b0; evt_wdata_i = 1'b0;
    timeout_i = tmo; irq_en_i = en;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(16'd4, 1'b1);
    chk("R1 idle", idle_o, 3'b000);
    chk("R1 accum_en", accum_en_o, 3'b111);
    chk("R1 evt", evt_o, 1'b0);
    chk("R1 irq_n", irq_n_o, 1'b1);
  endtask

  // A and B starve, C keeps receiving increments; timeout 4 ticks.
  task automatic t_entry_clear_exit();
    do_reset(16'd4, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 3'b100);
      cyc(1'b0, 3'b100); // tick-free cycle, must not count
    end
    chk("R2 not yet idle after 3 ticks", idle_o, 3'b000);
    chk("R6 no event yet", evt_o, 1'b0);
    cyc(1'b1, 3'b100);
    chk("R2 A,B idle on 4th tick", idle_o, 3'b011);
    chk("R3 accum gate", accum_en_o, 3'b100);
    chk("R6 evt with vector", evt_o, 1'b1);
    chk("R7 irq low", irq_n_o, 1'b0);
    cyc(1'b0, 3'b000, 1'b1, 1'b0);
    chk("R8 write 0 keeps evt", evt_o, 1'b1);
    cyc(1'b0, 3'b000, 1'b1, 1'b1);
    chk("R8 write 1 clears evt", evt_o, 1'b0);
    chk("R8 irq released", irq_n_o, 1'b1);
    chk("R8 vector kept", idle_o, 3'b011);
    cyc(1'b0, 3'b001);
    chk("R5 A leaves idle", idle_o, 3'b010);
    chk("R5 A gate back on", accum_en_o, 3'b101);
    chk("R6 evt on exit", evt_o, 1'b1);
    irq_en_i = 1'b0; #1;
    chk("R7 masked irq high", irq_n_o, 1'b1);
    irq_en_i = 1'b1; #1;
    chk("R7 unmasked irq low", irq_n_o, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_disable();
    do_reset(16'd0, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b1, 3'b000);
    chk("R4 zero timeout never idle", idle_o, 3'b000);
    chk("R4 no event", evt_o, 1'b0);
    timeout_i = 16'd2;
    cyc(1'b1, 3'b000);
    cyc(1'b1, 3'b000);
    chk("R2 all idle at 2 ticks", idle_o, 3'b111);
    cyc(1'b0, 3'b000, 1'b1, 1'b1);
    chk("R8 cleared", evt_o, 1'b0);
    timeout_i = 16'd0;
    cyc(1'b0, 3'b000);
    chk("R4 zero timeout forces exit", idle_o, 3'b000);
    chk("R4 exit raises evt", evt_o, 1'b1);
  endtask

  task automatic t_collide();
    do_reset(16'd1, 1'b1);
    cyc(1'b1, 3'b000);
    chk("R2 timeout 1 enters on first tick", idle_o, 3'b111);
    cyc(1'b0, 3'b000, 1'b1, 1'b1);
    chk("R8 cleared before collision", evt_o, 1'b0);
    cyc(1'b0, 3'b010, 1'b1, 1'b1);
    chk("R9 event beats clear", evt_o, 1'b1);
    chk("R9 B left idle", idle_o, 3'b101);
    cyc(1'b0, 3'b000, 1'b1, 1'b1);
    chk("R8 plain clear", evt_o, 1'b0);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_entry_clear_exit();
    t_disable();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule